// File: doc/BRIEF.md
# Pipeline Interlock and Stall Unit

This block detects the hazards that keep an in-order, five-stage pipeline from issuing its decode-stage instruction. It compares the source registers of the instruction in decode with the destinations of the older instructions still in the execute, memory and write-back stages. When the instruction in decode would read a register that an older instruction has not yet written, the unit freezes the program counter and the fetch/decode register and turns the slot entering execute into a no-op. No forwarding is done, so the stall lasts until the producer is far enough down the pipe that the register file delivers the new value.

The unit also covers a structural conflict. The pipeline has one memory port that serves both instruction fetch and data access. In any cycle where the memory stage performs a load or a store, fetch cannot use the port, and the unit raises the same freeze. A data stall and a structural stall in the same cycle produce a single freeze, so no instruction is lost or issued twice. The unit is purely combinational: the pipeline registers act on its outputs at the next clock edge.

Top module: `hz_interlock_unit`

## Requirements
- R1: When the decode instruction reads a register (rs with its use flag set, or rt with its use flag set) equal to the nonzero destination of the execute-stage instruction, and that instruction's write flag is 1, all three outputs are 1 in the same cycle.
- R2: The same match against the memory-stage instruction's destination also drives all three outputs to 1.
- R3: With WB_BYPASS=1 (the register file writes before it reads), a match against the write-back stage alone causes no stall. With WB_BYPASS=0, it stalls like R1.
- R4: A destination of register 0 never causes a stall, even when the write flag is 1 and the source fields are 0.
- R5: A stage whose write flag is 0 never causes a stall, whatever its destination field holds.
- R6: A source whose use flag is 0 is left out of the comparison. A matching field on an unused source causes no stall.
- R7: When the memory stage performs a data access (exmem_mem_access=1), all three outputs are 1, whatever the register fields are.
- R8: With no dependence and no data access, all three outputs are 0.
- R9: pc_hold, ifid_hold and idex_bubble are always equal. A data and a structural hazard in the same cycle give one stall cycle, not two.
- R10: In a running pipeline with WB_BYPASS=1, a consumer directly after its ALU producer waits 2 cycles and a consumer one instruction later waits 1. A load followed by a dependent instruction waits 2 cycles. A load followed by an independent instruction waits 1 cycle. With WB_BYPASS=0, a consumer directly after its producer waits 3 cycles.
- R11: Under any stall sequence, every instruction enters execute exactly once and in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | AW | First source register field of the decode instruction |
| id_rt | input | AW | Second source register field of the decode instruction |
| id_rs_used | input | 1 | The decode instruction reads id_rs |
| id_rt_used | input | 1 | The decode instruction reads id_rt |
| idex_rd | input | AW | Destination of the instruction in execute |
| idex_wen | input | 1 | The instruction in execute writes a register |
| exmem_rd | input | AW | Destination of the instruction in memory stage |
| exmem_wen | input | 1 | The instruction in memory stage writes a register |
| exmem_mem_access | input | 1 | The memory-stage instruction is a load or store |
| memwb_rd | input | AW | Destination of the instruction in write-back |
| memwb_wen | input | 1 | The instruction in write-back writes a register |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench builds two instances that share the same inputs. One uses the defaults (AW=5, WB_BYPASS=1, ZERO_REG_FIXED=1). The other sets WB_BYPASS=0, so a write-back match becomes a third stalling stage. This makes it possible to check both the shorter and the longer dependence penalty, and the claim that the write-back comparison is harmless only when the register file writes first. Short programs run through a model of the pipeline that is steered by the unit's outputs. These runs measure stall cycles and issue order for back-to-back and spaced dependences, dependent and independent loads, and writes to register 0.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Older in-flight stages whose destinations are compared against decode.
    typedef enum logic [1:0] {
        STG_IDEX  = 2'd0,
        STG_EXMEM = 2'd1,
        STG_MEMWB = 2'd2
    } stage_e;

    localparam int NUM_STAGES = 3;

    // Front-end control produced each cycle.
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
    } front_ctrl_t;

    // Per-stage mask of stages whose matches stall.
    function automatic logic [NUM_STAGES-1:0] stall_mask(input bit wb_bypass);
        logic [NUM_STAGES-1:0] m;
        m = '1;
        if (wb_bypass) m[STG_MEMWB] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
    parameter int AW             = 5,
    parameter bit ZERO_REG_FIXED = 1'b1
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] rt,
    input  logic          rs_used,
    input  logic          rt_used,
    input  logic [AW-1:0] dst,
    input  logic          dst_wen,
    output logic          hit
);
    logic dst_live;

    generate
        if (ZERO_REG_FIXED) begin : g_zero_fixed
            // Writes to register 0 are discarded, so nothing waits on them.
            assign dst_live = dst_wen && (dst != '0);
        end else begin : g_zero_plain
            assign dst_live = dst_wen;
        end
    endgenerate

    always_comb begin
        hit = dst_live && ((rs_used && (rs == dst)) || (rt_used && (rt == dst)));
    end
endmodule

// File: rtl/hz_raw_detect.sv
module hz_raw_detect
    import hz_pkg::*;
#(
    parameter int AW             = 5,
    parameter int NSTG           = NUM_STAGES,
    parameter bit WB_BYPASS      = 1'b1,
    parameter bit ZERO_REG_FIXED = 1'b1
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] rt,
    input  logic          rs_used,
    input  logic          rt_used,
    input  logic [AW-1:0] dst     [NSTG],
    input  logic          dst_wen [NSTG],
    output logic          raw_stall
);
    localparam logic [NSTG-1:0] STALL_EN = stall_mask(WB_BYPASS);

    logic [NSTG-1:0] hit_vec;

    generate
        for (genvar g = 0; g < NSTG; g++) begin : g_stage
            hz_src_cmp #(
                .AW             (AW),
                .ZERO_REG_FIXED (ZERO_REG_FIXED)
            ) u_cmp (
                .rs      (rs),
                .rt      (rt),
                .rs_used (rs_used),
                .rt_used (rt_used),
                .dst     (dst[g]),
                .dst_wen (dst_wen[g]),
                .hit     (hit_vec[g])
            );
        end
    endgenerate

    always_comb begin
        raw_stall = |(hit_vec & STALL_EN);
    end
endmodule

// File: rtl/hz_front_merge.sv
module hz_front_merge
    import hz_pkg::*;
(
    input  logic        raw_stall,
    input  logic        mem_port_busy,
    output front_ctrl_t ctrl
);
    logic any_stall;

    always_comb begin
        // One freeze covers both causes; the held decode slot re-presents
        // the same instruction next cycle, so it cannot be lost or doubled.
        any_stall        = raw_stall | mem_port_busy;
        ctrl.pc_hold     = any_stall;
        ctrl.ifid_hold   = any_stall;
        ctrl.idex_bubble = any_stall;
    end
endmodule

// File: rtl/hz_interlock_unit.sv
module hz_interlock_unit
    import hz_pkg::*;
#(
    parameter int AW             = 5,
    parameter bit WB_BYPASS      = 1'b1,
    parameter bit ZERO_REG_FIXED = 1'b1
) (
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          id_rs_used,
    input  logic          id_rt_used,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_wen,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_wen,
    input  logic          exmem_mem_access,
    input  logic [AW-1:0] memwb_rd,
    input  logic          memwb_wen,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);
    logic [AW-1:0] stg_dst [NUM_STAGES];
    logic          stg_wen [NUM_STAGES];
    logic          raw_stall;
    front_ctrl_t   ctrl_d;

    always_comb begin
        stg_dst[STG_IDEX]  = idex_rd;
        stg_wen[STG_IDEX]  = idex_wen;
        stg_dst[STG_EXMEM] = exmem_rd;
        stg_wen[STG_EXMEM] = exmem_wen;
        stg_dst[STG_MEMWB] = memwb_rd;
        stg_wen[STG_MEMWB] = memwb_wen;
    end

    hz_raw_detect #(
        .AW             (AW),
        .NSTG           (NUM_STAGES),
        .WB_BYPASS      (WB_BYPASS),
        .ZERO_REG_FIXED (ZERO_REG_FIXED)
    ) u_raw (
        .rs        (id_rs),
        .rt        (id_rt),
        .rs_used   (id_rs_used),
        .rt_used   (id_rt_used),
        .dst       (stg_dst),
        .dst_wen   (stg_wen),
        .raw_stall (raw_stall)
    );

    hz_front_merge u_merge (
        .raw_stall     (raw_stall),
        .mem_port_busy (exmem_mem_access),
        .ctrl          (ctrl_d)
    );

    always_comb begin
        pc_hold     = ctrl_d.pc_hold;
        ifid_hold   = ctrl_d.ifid_hold;
        idex_bubble = ctrl_d.idex_bubble;
    end
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int AW        = 5,
    parameter bit WB_BYPASS = 1'b1
) (
    input logic [AW-1:0] id_rs,
    input logic [AW-1:0] id_rt,
    input logic          id_rs_used,
    input logic          id_rt_used,
    input logic [AW-1:0] idex_rd,
    input logic          idex_wen,
    input logic [AW-1:0] exmem_rd,
    input logic          exmem_wen,
    input logic          exmem_mem_access,
    input logic [AW-1:0] memwb_rd,
    input logic          memwb_wen,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble
);
    logic src_hits_idex;
    logic src_hits_exmem;
    logic src_hits_memwb;

    always_comb begin
        src_hits_idex  = (id_rs_used && id_rs == idex_rd)  || (id_rt_used && id_rt == idex_rd);
        src_hits_exmem = (id_rs_used && id_rs == exmem_rd) || (id_rt_used && id_rt == exmem_rd);
        src_hits_memwb = (id_rs_used && id_rs == memwb_rd) || (id_rt_used && id_rt == memwb_rd);

        p_idex_dep_r1: assert (!(idex_wen && idex_rd != '0 && src_hits_idex) || idex_bubble);
        p_exmem_dep_r2: assert (!(exmem_wen && exmem_rd != '0 && src_hits_exmem) || idex_bubble);
        p_wb_bypass_r3: assert (!(WB_BYPASS && !idex_wen && !exmem_wen && !exmem_mem_access)
                                || !pc_hold);
        p_wb_nobypass_r3: assert (!(!WB_BYPASS && memwb_wen && memwb_rd != '0 && src_hits_memwb)
                                  || pc_hold);
        p_zero_dest_r4: assert (!(idex_rd == '0 && exmem_rd == '0 && memwb_rd == '0
                                  && !exmem_mem_access) || !idex_bubble);
        p_wen_off_r5: assert (!(!idex_wen && !exmem_wen && !memwb_wen && !exmem_mem_access)
                              || !ifid_hold);
        p_no_source_r6: assert (!(!id_rs_used && !id_rt_used && !exmem_mem_access) || !pc_hold);
        p_mem_port_r7: assert (!exmem_mem_access || (pc_hold && ifid_hold));
        p_agree_r9: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
    end
endmodule

bind hz_interlock_unit hz_interlock_chk #(
    .AW        (AW),
    .WB_BYPASS (WB_BYPASS)
) u_chk (
    .id_rs            (id_rs),
    .id_rt            (id_rt),
    .id_rs_used       (id_rs_used),
    .id_rt_used       (id_rt_used),
    .idex_rd          (idex_rd),
    .idex_wen         (idex_wen),
    .exmem_rd         (exmem_rd),
    .exmem_wen        (exmem_wen),
    .exmem_mem_access (exmem_mem_access),
    .memwb_rd         (memwb_rd),
    .memwb_wen        (memwb_wen),
    .pc_hold          (pc_hold),
    .ifid_hold        (ifid_hold),
    .idex_bubble      (idex_bubble)
);

// File: tb/test_hz_interlock_unit.sv
module test_hz_interlock_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] id_rs = '0, id_rt = '0, idex_rd = '0, exmem_rd = '0, memwb_rd = '0;
    logic id_rs_used = 1'b0, id_rt_used = 1'b0, idex_wen = 1'b0, exmem_wen = 1'b0;
    logic memwb_wen = 1'b0, exmem_mem_access = 1'b0;
    logic a_pc, a_ifid, a_bub, b_pc, b_ifid, b_bub;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    hz_interlock_unit #(.AW(AW), .WB_BYPASS(1'b1)) i_hz_interlock_unit (
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .idex_rd(idex_rd), .idex_wen(idex_wen), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
        .exmem_mem_access(exmem_mem_access), .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
        .pc_hold(a_pc), .ifid_hold(a_ifid), .idex_bubble(a_bub));

    hz_interlock_unit #(.AW(AW), .WB_BYPASS(1'b0)) i_hz_nobyp (
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .idex_rd(idex_rd), .idex_wen(idex_wen), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
        .exmem_mem_access(exmem_mem_access), .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
        .pc_hold(b_pc), .ifid_hold(b_ifid), .idex_bubble(b_bub));

    typedef struct {
        logic [AW-1:0] rs, rt, rd;
        bit rsu, rtu, wen, mem;
    } ins_t;

    ins_t prog [8];
    int   prog_n;

    function automatic ins_t mk(int rd, int rs, int rt, bit rtu, bit wen, bit mem);
        ins_t x;
        x.rd = AW'(rd); x.rs = AW'(rs); x.rt = AW'(rt);
        x.rsu = 1'b1; x.rtu = rtu; x.wen = wen; x.mem = mem;
        return x;
    endfunction

    task automatic check(string req, string what, logic [2:0] got, logic [2:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic clear_inputs();
        id_rs = '0; id_rt = '0; id_rs_used = 1'b0; id_rt_used = 1'b0;
        idex_rd = '0; idex_wen = 1'b0; exmem_rd = '0; exmem_wen = 1'b0;
        memwb_rd = '0; memwb_wen = 1'b0; exmem_mem_access = 1'b0;
    endtask

    // Settle and sample between clock edges.
    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_idle();
        clear_inputs(); settle();
        check("R8", "no hazard default", {a_pc, a_ifid, a_bub}, 3'b000);
        id_rs = 5'd3; id_rt = 5'd4; id_rs_used = 1; id_rt_used = 1;
        idex_rd = 5'd5; idex_wen = 1; exmem_rd = 5'd6; exmem_wen = 1; settle();
        check("R8", "distinct registers", {a_pc, a_ifid, a_bub}, 3'b000);
    endtask

    task automatic t_idex();
        clear_inputs(); id_rs = 5'd7; id_rs_used = 1; idex_rd = 5'd7; idex_wen = 1; settle();
        check("R1", "rs vs execute", {a_pc, a_ifid, a_bub}, 3'b111);
        clear_inputs(); id_rt = 5'd9; id_rt_used = 1; idex_rd = 5'd9; idex_wen = 1; settle();
        check("R1", "rt vs execute", {a_pc, a_ifid, a_bub}, 3'b111);
    endtask

    task automatic t_exmem();
        clear_inputs(); id_rt = 5'd12; id_rt_used = 1; exmem_rd = 5'd12; exmem_wen = 1; settle();
        check("R2", "rt vs memory stage", {a_pc, a_ifid, a_bub}, 3'b111);
    endtask

    task automatic t_memwb();
        clear_inputs(); id_rs = 5'd14; id_rs_used = 1; memwb_rd = 5'd14; memwb_wen = 1; settle();
        check("R3", "write-back match, bypass", {a_pc, a_ifid, a_bub}, 3'b000);
        check("R3", "write-back match, no bypass", {b_pc, b_ifid, b_bub}, 3'b111);
    endtask

    task automatic t_zero();
        clear_inputs(); id_rs_used = 1; id_rt_used = 1;
        idex_wen = 1; exmem_wen = 1; memwb_wen = 1; settle();
        check("R4", "register 0 bypass", {a_pc, a_ifid, a_bub}, 3'b000);
        check("R4", "register 0 no bypass", {b_pc, b_ifid, b_bub}, 3'b000);
    endtask

    task automatic t_wen_off();
        clear_inputs(); id_rs = 5'd2; id_rt = 5'd2; id_rs_used = 1; id_rt_used = 1;
        idex_rd = 5'd2; exmem_rd = 5'd2; memwb_rd = 5'd2; settle();
        check("R5", "write flags off", {b_pc, b_ifid, b_bub}, 3'b000);
    endtask

    task automatic t_unused();
        clear_inputs(); id_rs = 5'd8; id_rt = 5'd8; idex_rd = 5'd8; idex_wen = 1; settle();
        check("R6", "both sources unused", {a_pc, a_ifid, a_bub}, 3'b000);
        id_rs = 5'd1; id_rs_used = 1; settle();
        check("R6", "rt unused, rs differs", {a_pc, a_ifid, a_bub}, 3'b000);
    endtask

    task automatic t_struct();
        clear_inputs(); exmem_mem_access = 1; settle();
        check("R7", "data access blocks fetch", {a_pc, a_ifid, a_bub}, 3'b111);
        check("R7", "data access, no bypass", {b_pc, b_ifid, b_bub}, 3'b111);
        id_rs = 5'd4; id_rs_used = 1; exmem_rd = 5'd4; exmem_wen = 1; settle();
        check("R9", "data plus port conflict", {a_pc, a_ifid, a_bub}, 3'b111);
    endtask

    // Pipeline model driven by the unit's outputs.
    task automatic run_prog(string req, string name, bit use_b, int exp_stalls);
        int pc = 0, id = -1, ex = -1, me = -1, wb = -1;
        int stalls = 0, issued = 0;
        bit order_ok = 1'b1, stall;
        for (int cyc = 0; cyc < 64; cyc++) begin
            id_rs_used = (id >= 0) ? prog[id].rsu : 1'b0;
            id_rt_used = (id >= 0) ? prog[id].rtu : 1'b0;
            id_rs      = (id >= 0) ? prog[id].rs  : '0;
            id_rt      = (id >= 0) ? prog[id].rt  : '0;
            idex_rd    = (ex >= 0) ? prog[ex].rd  : '0;
            idex_wen   = (ex >= 0) ? prog[ex].wen : 1'b0;
            exmem_rd   = (me >= 0) ? prog[me].rd  : '0;
            exmem_wen  = (me >= 0) ? prog[me].wen : 1'b0;
            exmem_mem_access = (me >= 0) ? prog[me].mem : 1'b0;
            memwb_rd   = (wb >= 0) ? prog[wb].rd  : '0;
            memwb_wen  = (wb >= 0) ? prog[wb].wen : 1'b0;
            settle();
            stall = use_b ? b_pc : a_pc;
            @(posedge clk);
            if (pc >= prog_n && id < 0 && ex < 0 && me < 0 && wb < 0) break;
            wb = me; me = ex;
            if (stall) begin
                ex = -1;
                stalls++;
            end else begin
                ex = id;
                if (ex >= 0) begin
                    if (ex != issued) order_ok = 1'b0;
                    issued++;
                end
                id = (pc < prog_n) ? pc : -1;
                pc++;
            end
        end
        n_tests++;
        if (stalls != exp_stalls) begin
            n_fail++;
            $display("FAIL %s %s stall cycles: got %0d expected %0d", req, name, stalls, exp_stalls);
        end
        n_tests++;
        if (!order_ok || issued != prog_n) begin
            n_fail++;
            $display("FAIL R11 %s issue: got %0d in order=%0d expected %0d in order=1",
                     name, issued, order_ok, prog_n);
        end
    endtask

    task automatic t_seq();
        // add r1<-r2,r3 ; sub r4<-r1,r3
        prog[0] = mk(1, 2, 3, 1, 1, 0); prog[1] = mk(4, 1, 3, 1, 1, 0); prog_n = 2;
        run_prog("R10", "back-to-back bypass", 1'b0, 2);
        run_prog("R10", "back-to-back no bypass", 1'b1, 3);
        // add r1 ; or r8<-r9 ; and r6<-r1
        prog[1] = mk(8, 9, 10, 1, 1, 0); prog[2] = mk(6, 1, 7, 1, 1, 0); prog_n = 3;
        run_prog("R10", "one gap", 1'b0, 1);
        // load r1 ; add r2<-r1 (both stall causes merge)
        prog[0] = mk(1, 5, 0, 0, 1, 1); prog[1] = mk(2, 1, 3, 1, 1, 0); prog_n = 2;
        run_prog("R10", "dependent load", 1'b0, 2);
        run_prog("R9", "dependent load no bypass", 1'b1, 3);
        // load r1 ; add r5<-r6,r7
        prog[1] = mk(5, 6, 7, 1, 1, 0);
        run_prog("R10", "independent load", 1'b0, 1);
        // add r0 ; sub uses r0
        prog[0] = mk(0, 2, 3, 1, 1, 0); prog[1] = mk(4, 0, 0, 1, 1, 0);
        run_prog("R4", "register 0 chain", 1'b1, 0);
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_idex();
        t_exmem();
        t_memwb();
        t_zero();
        t_wen_off();
        t_unused();
        t_struct();
        t_seq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule